// File: doc/BRIEF.md
# Leading-Edge Dead-Time Inserter

This block sits between a phase-shift bridge modulator and the gate drivers of a full bridge. It receives the four raw complementary gate commands and holds back only the turn-on edge of each one by a programmable number of clock cycles. Each turn-off goes straight through. The result is dead time: the upper and lower switch of a leg are never commanded on together.

Each channel has its own delay field, so the inserted gap can be uneven between channels. This covers cases where a symmetric gap is not wanted, or where the driver paths have mismatched propagation. The delay logic is synchronous, so each delay is a whole number of clock periods. A channel latches its delay when its raw input is first seen high. A pulse shorter than its delay never reaches the output.

Top module: `edge_dly_gen`

## Requirements
- R1: The block has `CH_N` (default 4) independent channels. Channel i takes its delay from `dlyIn[i*CNT_W +: CNT_W]`, read as an unsigned count of clock cycles.
- R2: Let the rising edge of a clock be edge k, the first edge at which `rawIn[i]` is sampled high, and let D be the delay field. If D is 1 or more and the input stays high, `drvOut[i]` goes high just after edge k+D. It then stays high for as long as `rawIn[i]` stays high.
- R3: With a delay field of 0, `drvOut[i]` goes high just after edge k, which is one registered cycle.
- R4: When `rawIn[i]` goes low, `drvOut[i]` goes low in the same cycle, without waiting for a clock edge.
- R5: If `rawIn[i]` is sampled low at an edge before the count completes, `drvOut[i]` never goes high for that pulse. The count is discarded, and the next rising edge starts a fresh full delay.
- R6: The delay field is captured at edge k. Changing `dlyIn` while a count is running does not change that count.
- R7: Activity on one channel has no effect on any other channel's output. Channels started together with different delays each follow their own delay.
- R8: While `rst_n` is low, every `drvOut` bit is 0. An input that is already high when reset is released counts as a rising edge at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all delays count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rawIn | input | CH_N | Raw gate commands from the modulator |
| dlyIn | input | CH_N*CNT_W | Packed per-channel turn-on delays |
| drvOut | output | CH_N | Gated drive signals to the bridge |

## Verification
The assertions check on every cycle that the gate enable comes up only after the raw input was sampled high. They also check that it drops at the edge after the input is seen low, that the counter never steps below zero, and that a load captures the delay field presented with it. Only the bench scenarios can show the exact turn-on cycle for every delay value on every channel. The same holds for the combinational turn-off, the suppression of short pulses followed by a clean retrigger, immunity to delay writes during a count, and independence across channels running at once.

// File: rtl/edge_dly_pkg.sv
package edge_dly_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic clr;
  } dtStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ON    = 2'd2
  } dtState_e;
endpackage

// File: rtl/edge_dly_dp.sv
module edge_dly_dp
  import edge_dly_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dtStrobe_t        strobe,
  input  logic [CNT_W-1:0] dlyIn,
  output logic             dlyZero,
  output logic             isLast
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (strobe.clr) cnt <= '0;
    else if (strobe.load) cnt <= dlyIn;
    else if (strobe.dec) cnt <= cnt - ONE;
  end

  assign dlyZero = (dlyIn == '0);
  assign isLast  = (cnt == ONE);

  // R2: control issues at most one strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.load, strobe.dec, strobe.clr}));

  // R2: a running count never steps below zero
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dec |-> (cnt != '0));

  // R6: the delay is captured at the trigger edge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (cnt == $past(dlyIn)));
endmodule

// File: rtl/edge_dly_ctrl.sv
module edge_dly_ctrl
  import edge_dly_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rawIn,
  input  logic      dlyZero,
  input  logic      isLast,
  output dtStrobe_t strobe,
  output logic      gateOn
);
  dtState_e state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (!rawIn) begin
      strobe.clr = (state != ST_IDLE);
      stateNxt   = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobe.load = 1'b1;
          stateNxt    = dlyZero ? ST_ON : ST_COUNT;
        end
        ST_COUNT: begin
          strobe.dec = 1'b1;
          stateNxt   = isLast ? ST_ON : ST_COUNT;
        end
        default: stateNxt = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign gateOn = (state == ST_ON);

  // R3: the enable only rises after the raw input was sampled high
  a_r3_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOn) |-> $past(rawIn));

  // R5: a low raw input withdraws the enable at the next edge
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rawIn |=> !gateOn);
endmodule

// File: rtl/edge_dly_gen.sv
module edge_dly_gen
  import edge_dly_pkg::*;
#(
  parameter int CH_N  = 4,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CH_N-1:0]       rawIn,
  input  logic [CH_N*CNT_W-1:0] dlyIn,
  output logic [CH_N-1:0]       drvOut
);
  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    dtStrobe_t strobe;
    logic      dlyZero;
    logic      isLast;
    logic      gateOn;

    edge_dly_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rawIn  (rawIn[i]),
      .dlyZero(dlyZero),
      .isLast (isLast),
      .strobe (strobe),
      .gateOn (gateOn)
    );

    edge_dly_dp #(.CNT_W(CNT_W)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .dlyIn  (dlyIn[i*CNT_W +: CNT_W]),
      .dlyZero(dlyZero),
      .isLast (isLast)
    );

    // R4: turn-off passes through the AND gate without a register
    assign drvOut[i] = rawIn[i] & gateOn;
  end
endmodule

// File: tb/edge_dly_gen_tb.sv
module edge_dly_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CH_N  = 4;
  localparam int CNT_W = 4;
  localparam int DMAX  = (1 << CNT_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [CH_N-1:0]       rawIn = '0;
  logic [CH_N*CNT_W-1:0] dlyIn = '0;
  logic [CH_N-1:0]       drvOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  edge_dly_gen #(.CH_N(CH_N), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rawIn(rawIn), .dlyIn(dlyIn), .drvOut(drvOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [CH_N-1:0] act, input logic [CH_N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: drvOut=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // one pulse of `len` sampled-high edges on channel ch with delay d
  task automatic pulse(input int ch, input int d, input int len, input bit poke, input string req);
    @(negedge clk);
    dlyIn[ch*CNT_W +: CNT_W] = CNT_W'(d);
    rawIn[ch] = 1'b1;
    for (int m = 0; m < len; m++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (poke) dlyIn[ch*CNT_W +: CNT_W] = CNT_W'(DMAX - d); // R6 write mid-count
      check(req, drvOut, (m >= d) ? CH_N'(1) << ch : '0);
    end
    @(negedge clk);
    rawIn[ch] = 1'b0;
    #1;
    check("R4", drvOut, '0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs low, raw high at release acts as an edge
    dlyIn = {CNT_W'(0), CNT_W'(0), CNT_W'(0), CNT_W'(2)};
    rawIn = 4'b0001;
    repeat (3) @(posedge clk);
    #1;
    check("R8", drvOut, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R8", drvOut, (m >= 2) ? 4'b0001 : 4'b0000);
    end
    @(negedge clk);
    rawIn = '0;
    repeat (2) @(posedge clk);

    // R1 R2 R3: every delay value on every channel
    for (int ch = 0; ch < CH_N; ch++)
      for (int d = 0; d <= DMAX; d++)
        pulse(ch, d, d + 3, 1'b0, (d == 0) ? "R3" : "R2");

    // R5: short pulse suppressed, then clean retrigger with full delay
    for (int ch = 0; ch < CH_N; ch++)
      for (int d = 1; d <= DMAX; d += 3) begin
        pulse(ch, d, d, 1'b0, "R5");
        pulse(ch, d, d + 2, 1'b0, "R5");
      end

    // R6: delay writes during a count are ignored
    for (int d = 1; d <= DMAX; d += 2)
      pulse(2, d, d + 2, 1'b1, "R6");

    // R7: all channels together with distinct delays
    @(negedge clk);
    dlyIn = {CNT_W'(12), CNT_W'(0), CNT_W'(7), CNT_W'(3)};
    rawIn = 4'b1111;
    for (int m = 0; m < 15; m++) begin
      logic [CH_N-1:0] e;
      e = {m >= 12, 1'b1, m >= 7, m >= 3};
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R7", drvOut, e);
    end
    // R7 R4: dropping one channel leaves the others on
    @(negedge clk);
    rawIn[1] = 1'b0;
    #1;
    check("R7", drvOut, 4'b1101);
    @(negedge clk);
    rawIn = '0;
    #1;
    check("R4", drvOut, '0);
    repeat (2) @(posedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule